// File: doc/BRIEF.md
# Configurable Window Processing Pipeline

This block computes one result per image neighbourhood using a fixed three-step pipeline. Two N×N windows, A (image pixels) and B (mask, pattern or second image), arrive side by side with a single valid strobe. The first step combines each A/B element pair. The second step transforms each resulting element on its own. The third step folds all N² elements into one scalar through a registered binary tree. Each step takes its own opcode. A scalar parameter feeds the second step as a threshold level or a shift count.

Opcodes and the parameter are captured together with the windows and travel with them. A new window pair with a different operation can therefore enter on every clock, with no stalls. With suitable opcodes the block performs sum of absolute differences, convolution with a power-of-two divisor, mean and max filtering, image difference with or without thresholding, and greyscale or binary dilation and erosion. The per-element matrix Q leaves the pipeline after the second step, for operations that need no reduction. The scalar x leaves at the end of the tree.

Top module: `win_pe`

## Requirements
- R1: Step one registers, for every element e, R[e] = f(A[e], B[e]) one clock after `in_valid`. Pixels are unsigned and R is signed and `RW = 2*PIX_W+2` bits wide. `op_d` encoding: 0 AND, 1 OR, 2 XOR, 3 multiply, 4 add, 5 subtract A−B, 6 pass A, 7 A OR (NOT B), where NOT B is taken over PIX_W bits.
- R2: Step two registers Q[e] = g(R[e]) one clock later. `op_m` encoding: 0 pass, 1 absolute value, 2 threshold (1 when R ≥ `param` compared as signed, else 0), 5 logical NOT (1 when R is zero, else 0). Codes 6 and 7 pass.
- R3: `op_m` 3 is an arithmetic right shift and 4 is a left shift, both by `param[SHW-1:0]` with `SHW = clog2(RW)`. A left shift keeps only the low RW bits.
- R4: Step three folds all N² elements of Q, sign-extended to `XW = RW + 2*log2(N)` bits, in a tree with one register per level. `op_r` encoding: 0 sum, 1 bitwise AND, 2 bitwise OR, 3 signed max, 4 signed min. Codes 5 to 7 sum. The sum of N² full-scale products never overflows.
- R5: `q_valid` rises exactly 2 clocks after an accepted `in_valid`. `x_valid` rises exactly 2 + 2·log2(N) clocks after it.
- R6: `op_d`, `op_m`, `op_r` and `param` are sampled in the same cycle as the windows and stay tied to that window pair. Back-to-back inputs with differing opcodes each produce their own correct Q and x.
- R7: While `rst_n` is low, and in the first cycle after it, both `q_valid` and `x_valid` are 0.
- R8: A cycle without `in_valid` produces no Q and no x result. The count of results equals the count of accepted inputs.
- R9: These opcode triples give the named operations: SAD = (5,1,0), convolution with divisor 2^k = (3,3 with param k,0), greyscale dilation = (4,0,3), greyscale erosion = (5,0,4), binary erosion = (7,0,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the valid pipeline |
| in_valid | input | 1 | Window pair and controls valid this cycle |
| a_win | input | N*N*PIX_W | Window A, element i*N+j at bits [(i*N+j)*PIX_W +: PIX_W] |
| b_win | input | N*N*PIX_W | Window B, same layout as A |
| op_d | input | 3 | Element-pair operation code |
| op_m | input | 3 | Per-element transform code |
| op_r | input | 3 | Reduction code |
| param | input | RW | Signed threshold or shift count |
| q_out | output | N*N*RW | Matrix Q, signed elements, same ordering as the inputs |
| q_valid | output | 1 | q_out valid |
| x_out | output | XW | Signed reduced scalar |
| x_valid | output | 1 | x_out valid |

## Verification
The Q output of one window and the x output of a window issued 2·log2(N) cycles earlier appear in the same clock whenever inputs stream back to back. Each result is also computed under a different opcode set from its neighbours. The bench issues a long unbroken run of random windows with random opcodes and parameters, so both outputs are valid together most cycles. On every such cycle it matches each output against its own queue entry and its own expected arrival cycle. A swapped opcode, a misrouted pipeline stage or an off-by-one latency then shows up as a mismatch against the wrong window.

// File: rtl/win_pe.sv
module win_pe #(
  parameter int N     = 4,
  parameter int PIX_W = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [N*N*PIX_W-1:0]         a_win,
  input  logic [N*N*PIX_W-1:0]         b_win,
  input  logic [2:0]                   op_d,
  input  logic [2:0]                   op_m,
  input  logic [2:0]                   op_r,
  input  logic [2*PIX_W+1:0]           param,
  output logic [N*N*(2*PIX_W+2)-1:0]   q_out,
  output logic                         q_valid,
  output logic [2*PIX_W+1+2*$clog2(N):0] x_out,
  output logic                         x_valid
);
  localparam int E   = N * N;
  localparam int LV  = 2 * $clog2(N);
  localparam int RW  = 2 * PIX_W + 2;
  localparam int XW  = RW + LV;
  localparam int SHW = $clog2(RW);
  localparam int LAT = 2 + LV;

  function automatic logic signed [RW-1:0] fd(input logic [PIX_W-1:0] a, input logic [PIX_W-1:0] b,
                                              input logic [2:0] op);
    logic signed [RW-1:0] ea, eb;
    ea = $signed({{(RW-PIX_W){1'b0}}, a});
    eb = $signed({{(RW-PIX_W){1'b0}}, b});
    case (op)
      3'd0:    fd = ea & eb;
      3'd1:    fd = ea | eb;
      3'd2:    fd = ea ^ eb;
      3'd3:    fd = ea * eb;
      3'd4:    fd = ea + eb;
      3'd5:    fd = ea - eb;
      3'd6:    fd = ea;
      default: fd = $signed({{(RW-PIX_W){1'b0}}, a | ~b});
    endcase
  endfunction

  function automatic logic signed [RW-1:0] fm(input logic signed [RW-1:0] r, input logic [2:0] op,
                                              input logic signed [RW-1:0] p);
    logic [SHW-1:0] sh;
    sh = p[SHW-1:0];
    case (op)
      3'd1:    fm = (r < 0) ? -r : r;
      3'd2:    fm = (r >= p) ? RW'(1) : '0;
      3'd3:    fm = r >>> sh;
      3'd4:    fm = r << sh;
      3'd5:    fm = (r == 0) ? RW'(1) : '0;
      default: fm = r;
    endcase
  endfunction

  function automatic logic signed [XW-1:0] fr(input logic signed [XW-1:0] a, input logic signed [XW-1:0] b,
                                              input logic [2:0] op);
    case (op)
      3'd1:    fr = a & b;
      3'd2:    fr = a | b;
      3'd3:    fr = (a > b) ? a : b;
      3'd4:    fr = (a < b) ? a : b;
      default: fr = a + b;
    endcase
  endfunction

  // stage 1: element-pair operation
  logic                 v_s1, v_s2;
  logic [2:0]           opm_s1, opr_s1, opm_s2, opr_s2;
  logic signed [RW-1:0] par_s1;
  logic signed [RW-1:0] r [E];
  logic signed [RW-1:0] q [E];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_s1 <= 1'b0;
      v_s2 <= 1'b0;
    end else begin
      v_s1 <= in_valid;
      v_s2 <= v_s1;
    end
  end

  always_ff @(posedge clk) begin
    opm_s1 <= op_m;
    opr_s1 <= op_r;
    par_s1 <= $signed(param);
    opm_s2 <= opm_s1;
    opr_s2 <= opr_s1;
    for (int e = 0; e < E; e++) begin
      r[e] <= fd(a_win[e*PIX_W +: PIX_W], b_win[e*PIX_W +: PIX_W], op_d);
      q[e] <= fm(r[e], opm_s1, par_s1);
    end
  end

  for (genvar e = 0; e < E; e++) begin : g_qout
    assign q_out[e*RW +: RW] = q[e];
  end
  assign q_valid = v_s2;

  // stage 3: registered reduction tree
  for (genvar l = 0; l < LV; l++) begin : lv
    localparam int M = E >> (l + 1);
    logic signed [XW-1:0] src  [2*M];
    logic signed [XW-1:0] node [M];
    logic [2:0]           opi, opo;
    logic                 vi, vo;

    if (l == 0) begin : g_first
      for (genvar i = 0; i < 2*M; i++) begin : g_src
        assign src[i] = {{LV{q[i][RW-1]}}, q[i]};
      end
      assign opi = opr_s2;
      assign vi  = v_s2;
    end else begin : g_next
      for (genvar i = 0; i < 2*M; i++) begin : g_src
        assign src[i] = lv[l-1].node[i];
      end
      assign opi = lv[l-1].opo;
      assign vi  = lv[l-1].vo;
    end

    always_ff @(posedge clk) begin
      opo <= opi;
      for (int k = 0; k < M; k++) node[k] <= fr(src[2*k], src[2*k+1], opi);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) vo <= 1'b0;
      else        vo <= vi;
    end
  end

  assign x_out   = lv[LV-1].node[0];
  assign x_valid = lv[LV-1].vo;

  AST_Q_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 q_valid) else $error("q latency"); // R5
  AST_X_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##LAT x_valid) else $error("x latency"); // R5
  AST_NO_SPURIOUS_Q: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !q_valid) else $error("spurious q"); // R8

  always_ff @(posedge clk) begin
    if (rst_n && q_valid) begin
      for (int e = 0; e < E; e++) begin
        AST_BINARY_Q: assert (!(opm_s2 == 3'd2 || opm_s2 == 3'd5) || q[e] == 0 || q[e] == 1)
          else $error("non-binary q"); // R2
        AST_ABS_NONNEG: assert (opm_s2 != 3'd1 || q[e] >= 0)
          else $error("negative abs"); // R2
      end
    end
  end
endmodule

// File: tb/tb_win_pe.sv
`timescale 1ns/1ps
module tb_win_pe;
  localparam int N     = 4;
  localparam int PIX_W = 10;
  localparam int E     = N * N;
  localparam int LV    = 2 * $clog2(N);
  localparam int RW    = 2 * PIX_W + 2;
  localparam int XW    = RW + LV;
  localparam int SHW   = $clog2(RW);
  localparam int MAXI  = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [E*PIX_W-1:0] a_win = '0, b_win = '0;
  logic [2:0] op_d = '0, op_m = '0, op_r = '0;
  logic [RW-1:0] param = '0;
  logic [E*RW-1:0] q_out;
  logic q_valid;
  logic [XW-1:0] x_out;
  logic x_valid;

  win_pe #(.N(N), .PIX_W(PIX_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_win(a_win), .b_win(b_win),
    .op_d(op_d), .op_m(op_m), .op_r(op_r), .param(param),
    .q_out(q_out), .q_valid(q_valid), .x_out(x_out), .x_valid(x_valid));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, n_iss = 0, qi = 0, xi = 0;
  bit mon_on = 1'b0, finished = 1'b0;
  logic [E*RW-1:0] eq_q [MAXI];
  longint eq_x [MAXI];
  int eq_cyc [MAXI];
  string eq_tag [MAXI];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint tr(input longint v, input int w);
    longint m;
    m = longint'(1) << w;
    v = v & (m - 1);
    if (v >= m / 2) v = v - m;
    return v;
  endfunction

  function automatic longint mfd(input longint a, input longint b, input int op);
    longint pm;
    pm = (longint'(1) << PIX_W) - 1;
    case (op)
      0: return a & b;
      1: return a | b;
      2: return a ^ b;
      3: return a * b;
      4: return a + b;
      5: return a - b;
      6: return a;
      default: return a | (~b & pm);
    endcase
  endfunction

  function automatic longint mfm(input longint r, input int op, input longint p);
    int sh;
    sh = int'(p & ((1 << SHW) - 1));
    case (op)
      1: return (r < 0) ? -r : r;
      2: return (r >= p) ? 1 : 0;
      3: return r >>> sh;
      4: return tr(r << sh, RW);
      5: return (r == 0) ? 1 : 0;
      default: return r;
    endcase
  endfunction

  function automatic longint mfr(input longint a, input longint b, input int op);
    case (op)
      1: return a & b;
      2: return a | b;
      3: return (a > b) ? a : b;
      4: return (a < b) ? a : b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [E*PIX_W-1:0] mk(input int maxv);
    logic [E*PIX_W-1:0] w;
    for (int e = 0; e < E; e++) w[e*PIX_W +: PIX_W] = PIX_W'($urandom_range(maxv, 0));
    return w;
  endfunction

  // drive at a falling edge; the window is captured at the next rising edge
  task automatic issue(input logic [E*PIX_W-1:0] a, input logic [E*PIX_W-1:0] b,
                       input int d, input int m, input int rr, input longint p, input string tag);
    longint pv, rv, qv, xv;
    logic [E*RW-1:0] qe;
    pv = tr(p, RW);
    for (int e = 0; e < E; e++) begin
      rv = tr(mfd(longint'(a[e*PIX_W +: PIX_W]), longint'(b[e*PIX_W +: PIX_W]), d), RW);
      qv = tr(mfm(rv, m, pv), RW);
      qe[e*RW +: RW] = qv[RW-1:0];
      xv = (e == 0) ? qv : mfr(xv, qv, rr);
    end
    eq_q[n_iss] = qe;
    eq_x[n_iss] = tr(xv, XW);
    eq_cyc[n_iss] = cyc + 2;
    eq_tag[n_iss] = tag;
    n_iss++;
    a_win = a; b_win = b; op_d = 3'(d); op_m = 3'(m); op_r = 3'(rr);
    param = pv[RW-1:0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (q_valid) begin
        if (qi >= n_iss) chk(1'b0, "R8 extra q result", qi, n_iss);
        else begin
          chk(cyc == eq_cyc[qi], {eq_tag[qi], " R5 q timing"}, cyc, eq_cyc[qi]);
          chk(q_out == eq_q[qi], {eq_tag[qi], " q value"}, longint'(q_out[RW-1:0]), longint'(eq_q[qi][RW-1:0]));
          qi++;
        end
      end
      if (x_valid) begin
        if (xi >= n_iss) chk(1'b0, "R8 extra x result", xi, n_iss);
        else begin
          chk(cyc == eq_cyc[xi] + LV, {eq_tag[xi], " R5 x timing"}, cyc, eq_cyc[xi] + LV);
          chk(longint'($signed(x_out)) == eq_x[xi], {eq_tag[xi], " x value"},
              longint'($signed(x_out)), eq_x[xi]);
          xi++;
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [E*PIX_W-1:0] ones, full;
    void'($urandom(32'd2024));
    ones = '0;
    for (int e = 0; e < E; e++) ones[e*PIX_W +: PIX_W] = PIX_W'(1);
    full = '1;
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(q_valid == 1'b0 && x_valid == 1'b0, "R7 valids low in reset", {q_valid, x_valid}, 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(q_valid == 1'b0 && x_valid == 1'b0, "R7 valids low after reset", {q_valid, x_valid}, 0);
    mon_on = 1'b1;

    issue(mk(1023), mk(1023), 5, 1, 0, 0, "R9 SAD");
    issue(mk(1023), mk(15), 3, 3, 0, 4, "R9 convolution");
    issue(mk(1023), mk(200), 4, 0, 3, 0, "R9 dilation");
    issue(mk(1023), mk(1023), 5, 0, 4, 0, "R9 erosion");
    issue(mk(1), mk(1), 7, 0, 1, 0, "R9 binary erosion");
    issue(full, ones, 7, 0, 1, 0, "R1 A or not B");
    issue(mk(1023), mk(1023), 5, 2, 2, 100, "R2 threshold");
    issue(mk(1023), mk(1023), 5, 2, 0, -5, "R2 negative threshold");
    issue(mk(3), mk(3), 0, 5, 0, 0, "R2 NOT");
    issue(mk(1023), mk(1023), 5, 4, 3, 25, "R3 left shift wrap");
    issue(mk(1023), mk(1023), 5, 3, 4, 3, "R3 arithmetic right shift");
    issue(mk(1023), mk(1023), 1, 0, 2, 0, "R1 OR");
    issue(mk(1023), mk(1023), 2, 0, 0, 0, "R1 XOR");
    issue(mk(1023), mk(1023), 6, 3, 0, 4, "R1 pass mean");
    issue(full, full, 3, 0, 0, 0, "R4 full-scale sum");
    issue(mk(1023), mk(1023), 5, 6, 7, 0, "R4 default codes");
    repeat (LV + 6) @(negedge clk);
    chk(qi == n_iss && xi == n_iss, "R8 result count after gap", qi + xi, 2 * n_iss);

    for (int k = 0; k < 150; k++) begin
      issue(mk(1023), mk(1023), int'($urandom_range(7, 0)), int'($urandom_range(7, 0)),
            int'($urandom_range(7, 0)), longint'($urandom_range(600, 0)) - 300, "R6 streamed");
      if (k % 37 == 36) @(negedge clk);
    end
    repeat (LV + 6) @(negedge clk);
    chk(qi == n_iss, "R8 q count", qi, n_iss);
    chk(xi == n_iss, "R8 x count", xi, n_iss);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule